// File: doc/BRIEF.md
# Shuffled Min-Sum Column Processor

This block decodes one LDPC codeword over a small binary parity-check matrix, visiting the columns one at a time in a fixed sweep. For each column it looks up the channel LLR, rebuilds every check-to-variable (C2V) message that touches the column from compact per-row state, and forms the a-posteriori value (APP). It derives the new variable-to-check (V2C) messages from that APP and folds their magnitudes into a running two-minimum search per row, storing their signs. It emits the extrinsic value (APP minus channel LLR) for that column at once, so a downstream demapper can start on it without waiting for the sweep to end.

Each row keeps only its smallest and second-smallest V2C magnitude, the column of the smallest, and one sign bit per column. The C2V messages use normalized min-sum with a factor of 3/4. A sweep reads the state committed by the previous sweep and builds the next state beside it; the two swap at the end of the sweep. Decoding stops at the first sweep whose hard decisions satisfy every check, or after a fixed number of sweeps. The columns of the matrix should be listed in non-decreasing degree so that a pipelined variant never stalls. The block reads the channel LLR of the column named on its request port in the same cycle.

Top module: `smsd_col_proc`

## Requirements
- R1: After reset, busy, done, le_valid and success are 0 and iters is 0.
- R2: A start pulse while idle begins a decode at column 0 with all per-row state cleared, so the first sweep gives APP equal to the channel LLR and Le equal to 0; a start pulse while busy is ignored and the running sweep continues unchanged.
- R3: While busy, one column is processed per cycle in ascending index order. ch_col names the column whose ch_llr is read in that cycle. One cycle later le_valid is 1 and le_col, le_val and app_val describe that column.
- R4: The parity-check matrix is the parameter H_MASK, with bit r*N_COLS+c set when row r checks column c. For each row checking the column, the C2V magnitude is the row's second minimum if its stored index equals the column, and its first minimum otherwise. The magnitude is scaled to floor(3m/4). The C2V sign is the XOR of all the row's stored sign bits XOR the column's own stored bit. Rows that do not check the column contribute 0.
- R5: APP is the channel LLR plus the sum of C2V values, saturated to ±(2^(W-1)-1). Le is APP minus the channel LLR, saturated the same way. The hard decision of a column is 1 exactly when its APP is negative. No output ever takes the value -2^(W-1).
- R6: Each V2C value is APP minus that row's C2V, saturated, and split into a sign (1 when negative) and a magnitude. Each row tracks the two smallest magnitudes and the column of the smallest, using strict less-than so a tie keeps the earlier column. The running values start each sweep at the maximum magnitude with index 0, and they become the recovery state for the next sweep.
- R7: After a sweep whose hard decisions give even parity on every row, done pulses for one cycle, success is 1 and iters equals the number of sweeps run.
- R8: If MAX_ITER sweeps finish without satisfying every row, done pulses, success is 0 and iters equals MAX_ITER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding a codeword (used only when idle) |
| ch_col | output | CW | Column whose channel LLR is requested this cycle |
| ch_llr | input | W | Channel LLR of column ch_col, signed |
| le_valid | output | 1 | le_col, le_val and app_val hold a finished column |
| le_col | output | CW | Index of the finished column |
| le_val | output | W | Extrinsic LLR of that column, signed |
| app_val | output | W | APP of that column, signed; its sign is the hard decision |
| busy | output | 1 | A decode is running |
| done | output | 1 | One-cycle pulse when a decode ends |
| success | output | 1 | Last decode met every parity check |
| iters | output | IW | Sweeps used by the last decode |

## Verification
The bench uses the default build: 8 columns, 4 rows each checking 3 columns, 6-bit messages and a 15-sweep limit, with four degree-1 columns followed by four degree-2 columns. This matrix is small enough that a bench reference model can predict every Le and APP value of every sweep. An all-positive word converges in one sweep, and a single weak wrong bit is corrected in the second. An all-negative word never converges, because each row has odd weight, and so it reaches the sweep limit. Values at ±31 force saturation of the APP, V2C and Le paths.

// File: rtl/smsd_pkg.sv
package smsd_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } smsd_state_e;

endpackage

// File: rtl/smsd_c2v_unit.sv
// Rebuilds one row's check-to-variable message for the current column.
module smsd_c2v_unit #(
    parameter int W  = 6,
    parameter int CW = 3,
    localparam int MW = W - 1
) (
    input  logic                hit,
    input  logic [MW-1:0]       min1,
    input  logic [MW-1:0]       min2,
    input  logic [CW-1:0]       idx,
    input  logic [CW-1:0]       col,
    input  logic                parity,
    input  logic                own,
    output logic signed [W-1:0] c2v
);

    logic [MW-1:0]       mag_sel;
    logic [MW+1:0]       triple;
    logic [MW-1:0]       scaled;
    logic signed [W-1:0] pos;
    logic                neg;

    always_comb begin
        // the row's own column must not see its own magnitude
        mag_sel = (idx == col) ? min2 : min1;
        triple  = {2'b00, mag_sel} + {1'b0, mag_sel, 1'b0};
        scaled  = MW'(triple >> 2);
        pos     = {1'b0, scaled};
        neg     = parity ^ own;
        if (!hit)
            c2v = '0;
        else if (neg)
            c2v = -pos;
        else
            c2v = pos;
    end

endmodule

// File: rtl/smsd_v2c_unit.sv
// Forms one row's variable-to-check message in sign-magnitude form.
module smsd_v2c_unit #(
    parameter int W = 6,
    localparam int MW   = W - 1,
    localparam int MAXV = (2 ** (W - 1)) - 1
) (
    input  logic signed [W-1:0] app,
    input  logic signed [W-1:0] c2v,
    output logic                sgn,
    output logic [MW-1:0]       mag
);

    logic signed [W:0]   diff;
    logic signed [W-1:0] clip;

    always_comb begin
        diff = {app[W-1], app} - {c2v[W-1], c2v};
        if (diff > (W+1)'(MAXV))
            clip = W'(MAXV);
        else if (diff < -((W+1)'(MAXV)))
            clip = -(W'(MAXV));
        else
            clip = W'(diff);
        sgn = clip[W-1];
        mag = sgn ? MW'(-clip) : MW'(clip);
    end

endmodule

// File: rtl/smsd_min2_unit.sv
// Folds one magnitude into a row's running smallest pair and index.
module smsd_min2_unit #(
    parameter int MW = 5,
    parameter int CW = 3
) (
    input  logic          hit,
    input  logic [MW-1:0] mag,
    input  logic [CW-1:0] col,
    input  logic [MW-1:0] in_m1,
    input  logic [MW-1:0] in_m2,
    input  logic [CW-1:0] in_idx,
    output logic [MW-1:0] out_m1,
    output logic [MW-1:0] out_m2,
    output logic [CW-1:0] out_idx
);

    always_comb begin
        out_m1  = in_m1;
        out_m2  = in_m2;
        out_idx = in_idx;
        if (hit && (mag < in_m1)) begin
            out_m2  = in_m1;
            out_m1  = mag;
            out_idx = col;
        end else if (hit && (mag < in_m2)) begin
            out_m2  = mag;
        end
    end

endmodule

// File: rtl/smsd_col_proc.sv
module smsd_col_proc
    import smsd_pkg::*;
#(
    parameter int N_COLS   = 8,
    parameter int N_ROWS   = 4,
    parameter int W        = 6,
    parameter int MAX_ITER = 15,
    parameter logic [N_ROWS*N_COLS-1:0] H_MASK = 32'hC864_3291,
    localparam int CW = $clog2(N_COLS),
    localparam int IW = $clog2(MAX_ITER + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic [CW-1:0]       ch_col,
    input  logic signed [W-1:0] ch_llr,
    output logic                le_valid,
    output logic [CW-1:0]       le_col,
    output logic signed [W-1:0] le_val,
    output logic signed [W-1:0] app_val,
    output logic                busy,
    output logic                done,
    output logic                success,
    output logic [IW-1:0]       iters
);

    localparam int MW   = W - 1;
    localparam int MAXV = (2 ** (W - 1)) - 1;
    localparam int SW   = W + $clog2(N_ROWS + 1) + 1;

    typedef struct packed {
        smsd_state_e                     st;
        logic [CW-1:0]                   col;
        logic [IW-1:0]                   iter;
        logic [N_ROWS-1:0][MW-1:0]       om1;
        logic [N_ROWS-1:0][MW-1:0]       om2;
        logic [N_ROWS-1:0][CW-1:0]       oidx;
        logic [N_ROWS-1:0][N_COLS-1:0]   osg;
        logic [N_ROWS-1:0][MW-1:0]       nm1;
        logic [N_ROWS-1:0][MW-1:0]       nm2;
        logic [N_ROWS-1:0][CW-1:0]       nidx;
        logic [N_ROWS-1:0][N_COLS-1:0]   nsg;
        logic [N_COLS-1:0]               hard;
        logic                            lev;
        logic [CW-1:0]                   lecol;
        logic [W-1:0]                    le;
        logic [W-1:0]                    app;
        logic                            done;
        logic                            ok;
        logic [IW-1:0]                   iters;
    } regs_t;

    regs_t r_q, r_d;

    function automatic logic signed [W-1:0] clip_w(input logic signed [SW-1:0] v);
        if (v > SW'(MAXV))
            return W'(MAXV);
        else if (v < -(SW'(MAXV)))
            return -(W'(MAXV));
        else
            return W'(v);
    endfunction

    logic                running;
    logic                first_col;
    logic [N_ROWS-1:0]   hit_v;
    logic [N_ROWS-1:0]   row_odd;
    logic [N_ROWS-1:0]   v_sgn;
    logic signed [W-1:0] c2v    [N_ROWS];
    logic [MW-1:0]       v_mag  [N_ROWS];
    logic [MW-1:0]       upd_m1 [N_ROWS];
    logic [MW-1:0]       upd_m2 [N_ROWS];
    logic [CW-1:0]       upd_ix [N_ROWS];
    logic signed [SW-1:0] app_sum;
    logic signed [SW-1:0] le_wide;
    logic signed [W-1:0] app_sat;
    logic signed [W-1:0] le_sat;
    logic [N_COLS-1:0]   hard_nx;

    assign running   = (r_q.st == ST_RUN);
    assign first_col = (r_q.col == '0);

    // APP adder over every row's recovered message, then Le subtractor
    always_comb begin
        app_sum = SW'(ch_llr);
        for (int r = 0; r < N_ROWS; r++)
            app_sum = app_sum + SW'(c2v[r]);
        app_sat = clip_w(app_sum);
        le_wide = SW'(app_sat) - SW'(ch_llr);
        le_sat  = clip_w(le_wide);
        hard_nx = r_q.hard;
        hard_nx[r_q.col] = app_sat[W-1];
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic [MW-1:0] base_m1;
        logic [MW-1:0] base_m2;
        logic [CW-1:0] base_ix;

        assign hit_v[r] = H_MASK[r*N_COLS + int'(r_q.col)];
        assign base_m1  = first_col ? MW'(MAXV) : r_q.nm1[r];
        assign base_m2  = first_col ? MW'(MAXV) : r_q.nm2[r];
        assign base_ix  = first_col ? '0 : r_q.nidx[r];
        assign row_odd[r] = ^(hard_nx & H_MASK[r*N_COLS +: N_COLS]);

        smsd_c2v_unit #(.W(W), .CW(CW)) u_c2v (
            .hit    (hit_v[r]),
            .min1   (r_q.om1[r]),
            .min2   (r_q.om2[r]),
            .idx    (r_q.oidx[r]),
            .col    (r_q.col),
            .parity (^r_q.osg[r]),
            .own    (r_q.osg[r][r_q.col]),
            .c2v    (c2v[r])
        );

        smsd_v2c_unit #(.W(W)) u_v2c (
            .app (app_sat),
            .c2v (c2v[r]),
            .sgn (v_sgn[r]),
            .mag (v_mag[r])
        );

        smsd_min2_unit #(.MW(MW), .CW(CW)) u_min (
            .hit     (hit_v[r] & running),
            .mag     (v_mag[r]),
            .col     (r_q.col),
            .in_m1   (base_m1),
            .in_m2   (base_m2),
            .in_idx  (base_ix),
            .out_m1  (upd_m1[r]),
            .out_m2  (upd_m2[r]),
            .out_idx (upd_ix[r])
        );

        // committed row minima stay ordered
        assert_min_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
            r_q.om1[r] <= r_q.om2[r]);
    end

    always_comb begin
        r_d      = r_q;
        r_d.lev  = 1'b0;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_RUN;
                    r_d.col  = '0;
                    r_d.iter = '0;
                    r_d.om1  = '0;
                    r_d.om2  = '0;
                    r_d.oidx = '0;
                    r_d.osg  = '0;
                    r_d.nsg  = '0;
                    r_d.ok   = 1'b0;
                end
            end
            ST_RUN: begin
                r_d.lev   = 1'b1;
                r_d.lecol = r_q.col;
                r_d.le    = le_sat;
                r_d.app   = app_sat;
                r_d.hard  = hard_nx;
                for (int r = 0; r < N_ROWS; r++) begin
                    r_d.nm1[r]  = upd_m1[r];
                    r_d.nm2[r]  = upd_m2[r];
                    r_d.nidx[r] = upd_ix[r];
                    if (hit_v[r])
                        r_d.nsg[r][r_q.col] = v_sgn[r];
                end
                if (r_q.col == CW'(N_COLS - 1)) begin
                    r_d.om1  = r_d.nm1;
                    r_d.om2  = r_d.nm2;
                    r_d.oidx = r_d.nidx;
                    r_d.osg  = r_d.nsg;
                    if (!(|row_odd) || (r_q.iter == IW'(MAX_ITER - 1))) begin
                        r_d.st    = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.ok    = !(|row_odd);
                        r_d.iters = r_q.iter + 1'b1;
                    end else begin
                        r_d.iter = r_q.iter + 1'b1;
                        r_d.col  = '0;
                    end
                end else begin
                    r_d.col = r_q.col + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign ch_col   = r_q.col;
    assign le_valid = r_q.lev;
    assign le_col   = r_q.lecol;
    assign le_val   = r_q.le;
    assign app_val  = r_q.app;
    assign busy     = running;
    assign done     = r_q.done;
    assign success  = r_q.ok;
    assign iters    = r_q.iters;

    assert_le_follows_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        le_valid |-> le_col == $past(ch_col));

    // also covers R2: a start pulse cannot rewind a running sweep
    assert_col_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ch_col != CW'(N_COLS - 1)) |=> (busy && ch_col == CW'($past(ch_col) + 1'b1)));

    assert_no_full_negative_R5: assert property (@(posedge clk) disable iff (!rst_n)
        le_valid |-> (le_val != {1'b1, {MW{1'b0}}} && app_val != {1'b1, {MW{1'b0}}}));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_iters_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iters != '0 && iters <= IW'(MAX_ITER) && !busy));

    assert_fail_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !success) |-> iters == IW'(MAX_ITER));

endmodule

// File: tb/tb_smsd_col_proc.sv
`timescale 1ns/1ps
module tb_smsd_col_proc;

    localparam int NC = 8;
    localparam int NR = 4;
    localparam int WD = 6;
    localparam int MI = 15;
    localparam int CWB = 3;
    localparam int IWB = 4;
    localparam logic [31:0] HM = 32'hC864_3291;
    localparam int NV = 6;
    // entry: hand-derived sweep count (0 = none), then LLRs of columns 0..7
    localparam int TV [NV][NC+1] = '{
        '{1,  10, 10, 10, 10, 10, 10, 10, 10},
        '{2,  10, 10, 10, 10, -2, 10, 10, 10},
        '{15, -10, -10, -10, -10, -10, -10, -10, -10},
        '{0,  31, 31, 31, 31, 31, 31, 31, -31},
        '{0,  5, -3, 7, 2, -1, 9, -12, 4},
        '{0,  -6, 4, -2, 8, 3, -7, 1, -5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CWB-1:0] ch_col;
    logic signed [WD-1:0] ch_llr;
    logic le_valid;
    logic [CWB-1:0] le_col;
    logic signed [WD-1:0] le_val;
    logic signed [WD-1:0] app_val;
    logic busy, done, success;
    logic [IWB-1:0] iters;

    logic signed [WD-1:0] llr_mem [NC];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_le [MI*NC];
    int exp_app [MI*NC];
    int exp_n, exp_iters, exp_ok;

    always #10 clk = ~clk;

    assign ch_llr = llr_mem[ch_col];

    smsd_col_proc dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ch_col(ch_col), .ch_llr(ch_llr),
        .le_valid(le_valid), .le_col(le_col), .le_val(le_val), .app_val(app_val),
        .busy(busy), .done(done), .success(success), .iters(iters)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int satm(input int v);
        if (v > 31) return 31;
        if (v < -31) return -31;
        return v;
    endfunction

    // reference decoder written from R4..R8
    task automatic model();
        int om1[NR], om2[NR], oidx[NR], nm1[NR], nm2[NR], nidx[NR], cv[NR];
        int osg[NR][NC], nsg[NR][NC], hard[NC];
        for (int r = 0; r < NR; r++) begin
            om1[r] = 0; om2[r] = 0; oidx[r] = 0;
            for (int c = 0; c < NC; c++) begin osg[r][c] = 0; nsg[r][c] = 0; end
        end
        exp_n = 0; exp_ok = 0; exp_iters = MI;
        for (int it = 0; it < MI; it++) begin
            bit fail;
            for (int r = 0; r < NR; r++) begin nm1[r] = 31; nm2[r] = 31; nidx[r] = 0; end
            for (int c = 0; c < NC; c++) begin
                int sum, app;
                sum = int'(llr_mem[c]);
                for (int r = 0; r < NR; r++) begin
                    cv[r] = 0;
                    if (HM[r*NC+c]) begin
                        int mag, par, sc;
                        mag = (oidx[r] == c) ? om2[r] : om1[r];
                        sc = (mag * 3) / 4;
                        par = 0;
                        for (int k = 0; k < NC; k++) par ^= osg[r][k];
                        cv[r] = ((par ^ osg[r][c]) != 0) ? -sc : sc;
                        sum += cv[r];
                    end
                end
                app = satm(sum);
                exp_app[exp_n] = app;
                exp_le[exp_n] = satm(app - int'(llr_mem[c]));
                exp_n++;
                hard[c] = (app < 0) ? 1 : 0;
                for (int r = 0; r < NR; r++) begin
                    if (HM[r*NC+c]) begin
                        int v, m;
                        v = satm(app - cv[r]);
                        m = (v < 0) ? -v : v;
                        if (m < nm1[r]) begin nm2[r] = nm1[r]; nm1[r] = m; nidx[r] = c; end
                        else if (m < nm2[r]) nm2[r] = m;
                        nsg[r][c] = (v < 0) ? 1 : 0;
                    end
                end
            end
            fail = 1'b0;
            for (int r = 0; r < NR; r++) begin
                int p;
                om1[r] = nm1[r]; om2[r] = nm2[r]; oidx[r] = nidx[r];
                for (int c = 0; c < NC; c++) osg[r][c] = nsg[r][c];
                p = 0;
                for (int c = 0; c < NC; c++) if (HM[r*NC+c]) p ^= hard[c];
                if (p != 0) fail = 1'b1;
            end
            if (!fail) begin exp_ok = 1; exp_iters = it + 1; break; end
        end
    endtask

    task automatic run_case(input int v, input bit poke);
        int k, waited;
        bit got_done;
        for (int c = 0; c < NC; c++) llr_mem[c] = WD'(TV[v][c+1]);
        model();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        k = 0; waited = 0; got_done = 1'b0;
        while (!got_done && waited < 2000) begin
            @(negedge clk);
            waited++;
            start = (poke && waited == 5) ? 1'b1 : 1'b0;
            if (le_valid) begin
                if (k < exp_n) begin
                    check(le_col == CWB'(k % NC), "R3 le_col order", int'(le_col), k % NC);
                    check(int'(le_val) == exp_le[k], "R5 le_val", int'(le_val), exp_le[k]);
                    check(int'(app_val) == exp_app[k], "R4 R6 app_val", int'(app_val), exp_app[k]);
                    if (k < NC)
                        check(le_val == 0 && app_val == llr_mem[k], "R2 first sweep app",
                              int'(app_val), int'(llr_mem[k]));
                end
                k++;
            end
            if (done) got_done = 1'b1;
        end
        start = 1'b0;
        if (!got_done) check(1'b0, "R7 case watchdog", 0, 1);
        check(k == exp_n, "R2 R3 column count", k, exp_n);
        check(success == exp_ok[0], exp_ok != 0 ? "R7 success" : "R8 success",
              int'(success), exp_ok);
        check(int'(iters) == exp_iters, exp_ok != 0 ? "R7 iters" : "R8 iters",
              int'(iters), exp_iters);
        if (TV[v][0] != 0)
            check(int'(iters) == TV[v][0], "R7 R8 hand sweep count", int'(iters), TV[v][0]);
        @(negedge clk);
        check(!done && !busy, "R7 done single pulse", int'(done), 0);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) llr_mem[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !le_valid, "R1 reset control", int'({busy, done, le_valid}), 0);
        check(!success && iters == 0, "R1 reset result", int'(iters), 0);

        for (int v = 0; v < NV; v++) run_case(v, 1'b0);

        // start pulse during a run must not disturb it
        run_case(1, 1'b1);

        // reset in the middle of a decode
        for (int c = 0; c < NC; c++) llr_mem[c] = WD'(TV[2][c+1]);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !le_valid && !done, "R1 mid-run reset", int'(busy), 0);
        check(iters == 0 && !success, "R1 mid-run reset result", int'(iters), 0);
        run_case(0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule